// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an addressing-mode code, a base register value, an index register value and an instruction constant into the effective address of a load or store. Some modes also change the base register as a side effect. For those modes the unit returns a write-back strobe and the new base value, so the register file outside can commit the change. Two modes take their final address from memory. For these the unit raises an indirection request carrying the pointer's location, waits for the pointer word, and only then presents the address.

A request is accepted in any cycle where `reqReady` is high. A mode that needs no memory access delivers its address one cycle after acceptance. A mode that reads memory delivers its address one cycle after the pointer arrives. The register file, the memory port and the instruction decode are outside the unit.

Top module: `ea_unit`

## Requirements
- R1: Mode code 0 (absolute): one cycle after acceptance, `eaValid` pulses and `eaAddr` equals `constVal`.
- R2: Mode code 1 (register): `eaAddr` equals `baseVal`, one cycle after acceptance.
- R3: Mode code 2 (displacement): `eaAddr` equals `baseVal` plus the low DISP_W bits of `constVal`. Those bits are sign-extended, and the sum wraps modulo 2^ADDR_W.
- R4: Mode code 3 (post-increment): `eaAddr` equals the old `baseVal`, and `baseWe` is high with `baseNew` = `baseVal` + S. S = 1 << `sizeCode`, giving 1, 2, 4 or 8 bytes.
- R5: Mode code 4 (pre-decrement): `baseNew` = `baseVal` − S (wrapping), `eaAddr` equals that same new value, and `baseWe` is high.
- R6: Mode code 6 (scaled index): `eaAddr` = `constVal` + `baseVal` + (`idxVal` << `sizeCode`), modulo 2^ADDR_W.
- R7: Mode code 7 (memory indirect): one cycle after acceptance, `indReq` rises with `indAddr` = `constVal`, and it stays high until `ptrValid` is sampled. One cycle after that sample, `eaValid` pulses with `eaAddr` = `ptrData`, `indReq` falls, and `baseWe` stays low.
- R8: Mode code 5 (post-increment deferred): `indAddr` = `baseVal`. On completion, `eaAddr` = `ptrData` and `baseWe` is high with `baseNew` = `baseVal` + S.
- R9: `baseWe` is high only in a cycle where `eaValid` is high, and only for mode codes 3, 4 and 5. `eaValid` is a single-cycle pulse for each accepted request.
- R10: `reqReady` is low while an indirection is pending. `reqValid` has no effect while `reqReady` is low, and `ptrValid` has no effect while `indReq` is low.
- R11: After reset, `eaValid`, `baseWe` and `indReq` are low and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Address request present |
| reqReady | output | 1 | Unit can take a request this cycle |
| mode | input | 3 | Addressing-mode code (0..7, see requirements) |
| sizeCode | input | 2 | Operand size as log2 of bytes |
| baseVal | input | ADDR_W | Base register value |
| idxVal | input | ADDR_W | Index register value |
| constVal | input | ADDR_W | Instruction constant / displacement |
| ptrValid | input | 1 | Pointer word from memory is valid |
| ptrData | input | ADDR_W | Pointer word from memory |
| eaValid | output | 1 | Effective address valid (one-cycle pulse) |
| eaAddr | output | ADDR_W | Effective address |
| baseWe | output | 1 | Base register write-back enable |
| baseNew | output | ADDR_W | New base register value |
| indReq | output | 1 | Memory indirection requested |
| indAddr | output | ADDR_W | Address of the pointer word |

## Verification
On every cycle, the assertions check the handshake rules: the ties between write-back and valid, the exclusion of pending indirection and readiness, and the hand-off from pointer to address. They also check the absolute, post-increment and pre-decrement arithmetic against the sampled inputs. Only the bench's sweeps show the rest. They cover every mode against every operand size, with wrapping and negative-displacement values. They also vary the pointer latency, and they show that stray requests and pointer strobes outside a pending indirection change nothing.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [2:0] {
    MODE_ABS     = 3'd0,
    MODE_REG     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_POSTINC = 3'd3,
    MODE_PREDEC  = 3'd4,
    MODE_INCDEF  = 3'd5,
    MODE_SCALED  = 3'd6,
    MODE_MEMIND  = 3'd7
  } amode_e;

  typedef struct packed {
    logic capture;     // latch operands and computed results
    logic issueNow;    // result complete without memory access
    logic issueDefer;  // start memory indirection
    logic finishDefer; // pointer arrived, take it as the address
  } eaStrobe_t;

  function automatic logic needsPointer(amode_e m);
    return (m == MODE_INCDEF) || (m == MODE_MEMIND);
  endfunction

  function automatic logic writesBase(amode_e m);
    return (m == MODE_POSTINC) || (m == MODE_PREDEC) || (m == MODE_INCDEF);
  endfunction

endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  amode_e    reqMode,
  input  logic      ptrValid,
  output eaStrobe_t strobe,
  output logic      reqReady,
  output logic      eaValid,
  output logic      indReq,
  output logic      baseWe
);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e stateQ;
  logic   pendUpdQ;
  logic   accept;

  assign reqReady = (stateQ == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    strobe             = '0;
    strobe.capture     = accept;
    strobe.issueNow    = accept && !needsPointer(reqMode);
    strobe.issueDefer  = accept && needsPointer(reqMode);
    strobe.finishDefer = (stateQ == ST_WAIT) && ptrValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      pendUpdQ <= 1'b0;
      eaValid  <= 1'b0;
      indReq   <= 1'b0;
      baseWe   <= 1'b0;
    end else begin
      eaValid <= strobe.issueNow || strobe.finishDefer;
      baseWe  <= (strobe.issueNow && writesBase(reqMode)) ||
                 (strobe.finishDefer && pendUpdQ);
      if (strobe.issueDefer) begin
        stateQ   <= ST_WAIT;
        indReq   <= 1'b1;
        pendUpdQ <= writesBase(reqMode);
      end else if (strobe.finishDefer) begin
        stateQ   <= ST_IDLE;
        indReq   <= 1'b0;
        pendUpdQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  eaStrobe_t         strobe,
  input  amode_e            reqMode,
  input  logic [SZ_W-1:0]   sizeCode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [ADDR_W-1:0] constVal,
  input  logic [ADDR_W-1:0] ptrData,
  output logic [ADDR_W-1:0] eaAddr,
  output logic [ADDR_W-1:0] baseNew,
  output logic [ADDR_W-1:0] indAddr
);

  localparam int NUM_SIZES = 1 << SZ_W;
  localparam int EXT_W     = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] incBase;
  logic [ADDR_W-1:0] decBase;
  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] baseNext;
  logic [ADDR_W-1:0] shiftLane [NUM_SIZES];
  logic [ADDR_W-1:0] stepLane  [NUM_SIZES];

  // one pre-shifted lane per legal operand size
  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    assign shiftLane[k] = idxVal << k;
    assign stepLane[k]  = ADDR_W'(1) << k;
  end

  assign scaledIdx = shiftLane[sizeCode];
  assign stepBytes = stepLane[sizeCode];
  assign dispExt   = {{EXT_W{constVal[DISP_W-1]}}, constVal[DISP_W-1:0]};
  assign incBase   = baseVal + stepBytes;
  assign decBase   = baseVal - stepBytes;

  always_comb begin
    baseNext = baseVal;
    case (reqMode)
      MODE_ABS:     eaNext = constVal;
      MODE_REG:     eaNext = baseVal;
      MODE_DISP:    eaNext = baseVal + dispExt;
      MODE_POSTINC: begin eaNext = baseVal; baseNext = incBase; end
      MODE_PREDEC:  begin eaNext = decBase; baseNext = decBase; end
      MODE_INCDEF:  begin eaNext = baseVal; baseNext = incBase; end
      MODE_SCALED:  eaNext = constVal + baseVal + scaledIdx;
      default:      eaNext = constVal;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eaAddr  <= '0;
      baseNew <= '0;
      indAddr <= '0;
    end else if (strobe.capture) begin
      eaAddr  <= eaNext;
      baseNew <= baseNext;
      indAddr <= (reqMode == MODE_MEMIND) ? constVal : baseVal;
    end else if (strobe.finishDefer) begin
      eaAddr  <= ptrData;
    end
  end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        mode,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic [ADDR_W-1:0] constVal,
  input  logic              ptrValid,
  input  logic [ADDR_W-1:0] ptrData,
  output logic              eaValid,
  output logic [ADDR_W-1:0] eaAddr,
  output logic              baseWe,
  output logic [ADDR_W-1:0] baseNew,
  output logic              indReq,
  output logic [ADDR_W-1:0] indAddr
);

  eaStrobe_t strobe;
  amode_e    reqMode;

  assign reqMode = amode_e'(mode);

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqMode  (reqMode),
    .ptrValid (ptrValid),
    .strobe   (strobe),
    .reqReady (reqReady),
    .eaValid  (eaValid),
    .indReq   (indReq),
    .baseWe   (baseWe)
  );

  ea_datapath #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SZ_W(2)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqMode  (reqMode),
    .sizeCode (sizeCode),
    .baseVal  (baseVal),
    .idxVal   (idxVal),
    .constVal (constVal),
    .ptrData  (ptrData),
    .eaAddr   (eaAddr),
    .baseNew  (baseNew),
    .indAddr  (indAddr)
  );

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [2:0]        mode,
  input logic [1:0]        sizeCode,
  input logic [ADDR_W-1:0] baseVal,
  input logic [ADDR_W-1:0] constVal,
  input logic              ptrValid,
  input logic [ADDR_W-1:0] ptrData,
  input logic              eaValid,
  input logic [ADDR_W-1:0] eaAddr,
  input logic              baseWe,
  input logic [ADDR_W-1:0] baseNew,
  input logic              indReq
);

  logic fire;
  assign fire = reqValid && reqReady;

  p_abs_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    fire && mode == 3'd0 |=> eaValid && eaAddr == $past(constVal));

  p_postinc_r4: assert property (@(posedge clk) disable iff (!rstN)
    fire && mode == 3'd3 |=> eaValid && baseWe && eaAddr == $past(baseVal)
      && baseNew == $past(baseVal) + (ADDR_W'(1) << $past(sizeCode)));

  p_predec_r5: assert property (@(posedge clk) disable iff (!rstN)
    fire && mode == 3'd4 |=> eaValid && baseWe && eaAddr == baseNew
      && baseNew == $past(baseVal) - (ADDR_W'(1) << $past(sizeCode)));

  p_ptr_handoff_r7: assert property (@(posedge clk) disable iff (!rstN)
    indReq && ptrValid |=> eaValid && !indReq && eaAddr == $past(ptrData));

  p_ind_issue_r7: assert property (@(posedge clk) disable iff (!rstN)
    fire && mode == 3'd7 |=> indReq && !eaValid && !baseWe);

  p_we_with_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |-> eaValid);

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    eaValid && !(indReq && ptrValid) |=> !eaValid || $past(fire));

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rstN)
    indReq |-> !reqReady);

  p_hold_wait_r10: assert property (@(posedge clk) disable iff (!rstN)
    indReq && !ptrValid |=> indReq && !eaValid);

endmodule

bind ea_unit ea_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .mode     (mode),
  .sizeCode (sizeCode),
  .baseVal  (baseVal),
  .constVal (constVal),
  .ptrValid (ptrValid),
  .ptrData  (ptrData),
  .eaValid  (eaValid),
  .eaAddr   (eaAddr),
  .baseWe   (baseWe),
  .baseNew  (baseNew),
  .indReq   (indReq)
);

// File: tb/ea_unit_tb.sv
module ea_unit_tb;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    mode = '0;
  logic [1:0]    sizeCode = '0;
  logic [AW-1:0] baseVal = '0, idxVal = '0, constVal = '0, ptrData = '0;
  logic          ptrValid = 1'b0;
  logic          eaValid, baseWe, indReq;
  logic [AW-1:0] eaAddr, baseNew, indAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ea_unit #(.ADDR_W(AW), .DISP_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .mode(mode), .sizeCode(sizeCode), .baseVal(baseVal), .idxVal(idxVal),
    .constVal(constVal), .ptrValid(ptrValid), .ptrData(ptrData),
    .eaValid(eaValid), .eaAddr(eaAddr), .baseWe(baseWe), .baseNew(baseNew),
    .indReq(indReq), .indAddr(indAddr)
  );

  task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input int m);
    case (m)
      0: return "R1"; 1: return "R2"; 2: return "R3"; 3: return "R4";
      4: return "R5"; 5: return "R8"; 6: return "R6"; default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!eaValid, "R11 eaValid", AW'(eaValid), 0);
    check(!baseWe,  "R11 baseWe",  AW'(baseWe), 0);
    check(!indReq,  "R11 indReq",  AW'(indReq), 0);
    check(reqReady, "R11 reqReady", AW'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int i = 0; i < 6; i++) begin
          logic [AW-1:0] b, x, c, p, step, expEa, expBase;
          bit upd;
          bit defer;
          b = (i == 0) ? '0 : (i == 1) ? 32'hFFFF_FFFC : AW'(i) * 32'h9E37_79B9 + 32'h1000;
          x = AW'(i) * 32'h0123_4567 + 32'h11;
          c = (i % 2 == 0) ? (32'h0000_8004 + AW'(i) * 32'h0101_0000)
                           : (32'h0000_7FF0 + AW'(i) * 32'h0303_0000);
          p = 32'hC0DE_0000 + AW'(m * 100 + s * 10 + i);
          step = AW'(1) << s;
          upd = (m == 3) || (m == 4) || (m == 5);
          defer = (m == 5) || (m == 7);
          expBase = (m == 4) ? b - step : b + step;
          case (m)
            0: expEa = c;
            1: expEa = b;
            2: expEa = b + {{16{c[15]}}, c[15:0]};
            3: expEa = b;
            4: expEa = b - step;
            6: expEa = c + b + (x << s);
            default: expEa = p;
          endcase

          if (defer && i == 2) begin
            // R10 stray pointer strobe while idle
            ptrValid = 1'b1; ptrData = 32'hDEAD_BEEF;
            @(negedge clk);
            ptrValid = 1'b0;
            check(!eaValid && !indReq, "R10 stray ptrValid", AW'(eaValid), 0);
          end

          reqValid = 1'b1; mode = 3'(m); sizeCode = 2'(s);
          baseVal = b; idxVal = x; constVal = c;
          @(negedge clk);
          reqValid = 1'b0;

          if (!defer) begin
            check(eaValid, {reqOf(m), " eaValid"}, AW'(eaValid), 1);
            check(eaAddr == expEa, {reqOf(m), " eaAddr"}, eaAddr, expEa);
            check(baseWe == upd, "R9 baseWe", AW'(baseWe), AW'(upd));
            if (upd) check(baseNew == expBase, {reqOf(m), " baseNew"}, baseNew, expBase);
          end else begin
            check(indReq, {reqOf(m), " indReq"}, AW'(indReq), 1);
            check(indAddr == ((m == 7) ? c : b), {reqOf(m), " indAddr"}, indAddr,
                  (m == 7) ? c : b);
            check(!reqReady && !eaValid, "R10 busy", AW'(reqReady), 0);
            // intruding request while busy must be ignored
            reqValid = 1'b1; mode = 3'd0; constVal = 32'h5555_AAAA;
            @(negedge clk);
            reqValid = 1'b0;
            for (int w = 0; w < (i + s) % 3; w++) begin
              check(indReq && !eaValid, "R10 wait", AW'(indReq), 1);
              @(negedge clk);
            end
            ptrValid = 1'b1; ptrData = p;
            @(negedge clk);
            ptrValid = 1'b0; ptrData = '0;
            check(eaValid, {reqOf(m), " done"}, AW'(eaValid), 1);
            check(eaAddr == expEa, {reqOf(m), " eaAddr"}, eaAddr, expEa);
            check(!indReq, {reqOf(m), " indReq drop"}, AW'(indReq), 0);
            check(baseWe == upd, "R9 baseWe defer", AW'(baseWe), AW'(upd));
            if (upd) check(baseNew == expBase, "R8 baseNew", baseNew, expBase);
          end
          @(negedge clk);
          // R9 single pulse; R10 intruder not accepted
          check(!eaValid && !baseWe && !indReq, "R9 pulse", AW'(eaValid), 0);
          check(reqReady, "R10 ready", AW'(reqReady), 1);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule